// File: doc/BRIEF.md
# Receive Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept or discarded, based on its 48-bit destination address. Software programs two station addresses, a 64-entry group table and a small control word through a simple write port. For each frame, the receive path pulses a start signal together with the frame's total byte count, and then streams the destination address one byte per accepted cycle, in wire order.

The address is checked against the two station addresses and the all-ones broadcast address. It is also folded into a 6-bit index that selects one bit of the group table, which acts as a one-hash Bloom filter. By default only multicast addresses consult the table, and a control bit can extend the table lookup to individual addresses. A frame passes if any enabled check hits and the frame is long enough to carry two addresses.

The decision appears as a one-cycle valid strobe with an accept flag. Configuration is snapshotted when a frame starts, so reprogramming never disturbs a frame already in flight.

Top module: `af_rx_filter`

## Requirements
- R1: Station address 0 is written as a low word (select 0), holding destination bytes 0..3 with byte 0 in bits 7:0, and a high word (select 1), holding bytes 4 and 5 in bits 15:0. With control bit 0 set, a destination equal to it is accepted.
- R2: Station address 1 uses selects 2 (low) and 3 (high) with the same byte layout. It is matched only while control bit 1 is set.
- R3: With control bit 3 set, the destination FF:FF:FF:FF:FF:FF is accepted. With control bit 3 clear, broadcast gets no special treatment.
- R4: The group index is the XOR of the eight 6-bit groups of the 48-bit address. In that address, byte k bit i sits at position 8k+i, and group j covers positions 6j..6j+5 with the lowest position as the index LSB. Index 0..31 selects that bit of the table low word (select 4). Index 32..63 selects bit index-32 of the high word (select 5).
- R5: When control bit 2 is clear, an address whose byte 0 bit 0 is 0 never hits the group table. When control bit 2 is set, such addresses are looked up too.
- R6: A frame is accepted when any enabled station match, an enabled broadcast match or a table hit occurs. Otherwise it is dropped. The control word is written with select 6 in bits 3:0, and selects 7 and above are ignored.
- R7: A frame whose announced length is below 12 bytes is always dropped. A frame of exactly 12 bytes is judged normally.
- R8: The decision strobe is high for exactly one cycle, the cycle after the sixth address byte is taken. Idle cycles between bytes only delay it. Bytes beyond the sixth, or bytes arriving before any frame start, produce no strobe.
- R9: The configuration in force for a frame is the one programmed before its start pulse. A write made during a frame only affects later frames.
- R10: After reset the strobe is low and all programmed state is zero, so every frame is dropped until software enables a check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration word select (0..6 used) |
| cfg_wdata | input | 32 | Configuration write data |
| frm_start | input | 1 | Frame start pulse (no byte in this cycle) |
| frm_len | input | LEN_W | Total frame length in bytes, sampled with frm_start |
| rx_vld | input | 1 | Destination byte valid |
| rx_byte | input | 8 | Destination byte, wire order |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Accept (1) or drop (0), meaningful with dec_vld |

## Verification
A corrupted byte counter shows up at once as a strobe that is missing, early or doubled around the sixth byte. A wrongly placed captured byte, or a bad snapshot of the configuration, flips the accept flag on the very next strobe for at least one combination of control bits. That is why the bench sweeps every control word against station, broadcast, multicast and individual addresses, and walks a single table bit through all 64 index values. Each sweep predicts the result arithmetically from the fold rule. A wrong fold or table-half selection therefore shows on the first frame that aims at the affected index.

// File: rtl/af_pkg.sv
package af_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int HASH_W     = 6;
    localparam int TBL_N      = 1 << HASH_W;
    localparam int FOLD_N     = ADDR_W / HASH_W;
    localparam int WORD_W     = 32;
    localparam int CTL_W      = 4;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int SEL_W      = 3;

    localparam int CTL_STA0     = 0;
    localparam int CTL_STA1     = 1;
    localparam int CTL_HASH_ALL = 2;
    localparam int CTL_BCAST    = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_STA0_LO = 3'd0,
        SEL_STA0_HI = 3'd1,
        SEL_STA1_LO = 3'd2,
        SEL_STA1_HI = 3'd3,
        SEL_TBL_LO  = 3'd4,
        SEL_TBL_HI  = 3'd5,
        SEL_CTL     = 3'd6
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] sta0;
        logic [ADDR_W-1:0] sta1;
        logic [TBL_N-1:0]  tbl;
        logic [CTL_W-1:0]  ctl;
    } cfg_t;
endpackage

// File: rtl/af_cfg_regs.sv
module af_cfg_regs
    import af_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              capture,
    output cfg_t              act_cfg
);
    typedef struct packed {
        cfg_t prog;
        cfg_t act;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_STA0_LO: st_d.prog.sta0[WORD_W-1:0]      = wr_data;
                SEL_STA0_HI: st_d.prog.sta0[ADDR_W-1:WORD_W] = wr_data[ADDR_W-WORD_W-1:0];
                SEL_STA1_LO: st_d.prog.sta1[WORD_W-1:0]      = wr_data;
                SEL_STA1_HI: st_d.prog.sta1[ADDR_W-1:WORD_W] = wr_data[ADDR_W-WORD_W-1:0];
                SEL_TBL_LO:  st_d.prog.tbl[WORD_W-1:0]       = wr_data;
                SEL_TBL_HI:  st_d.prog.tbl[TBL_N-1:WORD_W]   = wr_data[TBL_N-WORD_W-1:0];
                SEL_CTL:     st_d.prog.ctl                   = wr_data[CTL_W-1:0];
                default: ;
            endcase
        end
        if (capture) begin
            st_d.act = st_q.prog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
endmodule

// File: rtl/af_addr_collect.sv
module af_addr_collect
    import af_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr,
    output logic              len_ok,
    output logic              done
);
    localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);
    localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              len_ok;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (frm_start) begin
            st_d.cnt    = '0;
            st_d.len_ok = (frm_len >= LEN_MIN);
        end else if (byte_vld && (st_q.cnt != CNT_IDLE)) begin
            st_d.addr[int'(st_q.cnt)*BYTE_W +: BYTE_W] = byte_in;
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.done = (st_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cnt    <= CNT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr   = st_q.addr;
    assign len_ok = st_q.len_ok;
    assign done   = st_q.done;
endmodule

// File: rtl/af_hash_fold.sv
module af_hash_fold
    import af_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] idx
);
    logic [HASH_W-1:0] part [FOLD_N+1];

    assign part[0] = '0;

    for (genvar g = 0; g < FOLD_N; g++) begin : g_fold
        assign part[g+1] = part[g] ^ addr[g*HASH_W +: HASH_W];
    end

    assign idx = part[FOLD_N];
endmodule

// File: rtl/af_decide.sv
module af_decide
    import af_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  cfg_t              cfg,
    input  logic              len_ok,
    output logic              accept
);
    logic [HASH_W-1:0] hidx;
    logic              hit_sta0;
    logic              hit_sta1;
    logic              hit_bcast;
    logic              hit_tbl;
    logic              grp_addr;

    af_hash_fold u_fold (
        .addr (addr),
        .idx  (hidx)
    );

    always_comb begin
        grp_addr  = addr[0];
        hit_sta0  = cfg.ctl[CTL_STA0]  && (addr == cfg.sta0);
        hit_sta1  = cfg.ctl[CTL_STA1]  && (addr == cfg.sta1);
        hit_bcast = cfg.ctl[CTL_BCAST] && (&addr);
        hit_tbl   = (grp_addr || cfg.ctl[CTL_HASH_ALL]) && cfg.tbl[hidx];
        accept    = len_ok && (hit_sta0 || hit_sta1 || hit_bcast || hit_tbl);
    end
endmodule

// File: rtl/af_rx_filter.sv
module af_rx_filter
    import af_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             frm_start,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             rx_vld,
    input  logic [7:0]       rx_byte,
    output logic             dec_vld,
    output logic             dec_accept
);
    cfg_t              act_cfg;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_len_ok;
    logic              cap_done;

    af_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .capture (frm_start),
        .act_cfg (act_cfg)
    );

    af_addr_collect #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_start (frm_start),
        .frm_len   (frm_len),
        .byte_vld  (rx_vld),
        .byte_in   (rx_byte),
        .addr      (cap_addr),
        .len_ok    (cap_len_ok),
        .done      (cap_done)
    );

    af_decide u_dec (
        .addr   (cap_addr),
        .cfg    (act_cfg),
        .len_ok (cap_len_ok),
        .accept (dec_accept)
    );

    assign dec_vld = cap_done;
endmodule

// File: rtl/af_rx_filter_chk.sv
module af_rx_filter_chk
    import af_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_start,
    input logic [LEN_W-1:0]  frm_len,
    input logic              dec_vld,
    input logic              dec_accept,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              cap_len_ok,
    input cfg_t              act_cfg
);
    logic short_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
        end else if (frm_start) begin
            short_q <= (int'(frm_len) < MIN_LEN);
        end
    end

    p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_vld |=> !dec_vld);

    p_start_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !dec_vld);

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_start |=> $stable(act_cfg));

    p_short_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && short_q) |-> !dec_accept);

    p_bcast_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && cap_len_ok && act_cfg.ctl[CTL_BCAST] && (&cap_addr)) |-> dec_accept);

    p_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && (act_cfg.ctl == '0) && !cap_addr[0]) |-> !dec_accept);
endmodule

bind af_rx_filter af_rx_filter_chk #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_start  (frm_start),
    .frm_len    (frm_len),
    .dec_vld    (dec_vld),
    .dec_accept (dec_accept),
    .cap_addr   (cap_addr),
    .cap_len_ok (cap_len_ok),
    .act_cfg    (act_cfg)
);

// File: tb/tb_af_rx_filter.sv
module tb_af_rx_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        frm_start;
    logic [15:0] frm_len;
    logic        rx_vld;
    logic [7:0]  rx_byte;
    logic        dec_vld;
    logic        dec_accept;

    int total = 0;
    int bad   = 0;

    logic [47:0] m_sta0, m_sta1;
    logic [63:0] m_tbl;
    logic [3:0]  m_ctl;

    always #10 clk = ~clk;

    af_rx_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frm_start(frm_start), .frm_len(frm_len),
        .rx_vld(rx_vld), .rx_byte(rx_byte), .dec_vld(dec_vld),
        .dec_accept(dec_accept)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] fold(input logic [47:0] a);
        logic [5:0] h = '0;
        for (int j = 0; j < 8; j++) h ^= a[6*j +: 6];
        return h;
    endfunction

    function automatic logic model(input logic [47:0] a, input int len);
        logic hit;
        hit = (a[0] || m_ctl[2]) && m_tbl[fold(a)];
        return (len >= 12) && ((m_ctl[0] && a == m_sta0) || (m_ctl[1] && a == m_sta1) ||
                               (m_ctl[3] && (&a)) || hit);
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: m_sta0[31:0]  = data;
            3'd1: m_sta0[47:32] = data[15:0];
            3'd2: m_sta1[31:0]  = data;
            3'd3: m_sta1[47:32] = data[15:0];
            3'd4: m_tbl[31:0]   = data;
            3'd5: m_tbl[63:32]  = data;
            3'd6: m_ctl         = data[3:0];
            default: ;
        endcase
    endtask

    // One frame; returns the accept flag seen with the strobe and checks the pulse shape (R8).
    task automatic frame(input logic [47:0] a, input int len, input bit gap, input bit extra,
                         input bit mid_wr, input logic [3:0] mid_ctl, output logic acc);
        frm_start = 1'b1; frm_len = 16'(len);
        @(negedge clk);
        frm_start = 1'b0;
        for (int b = 0; b < 6; b++) begin
            rx_vld = 1'b1; rx_byte = a[8*b +: 8];
            if (b == 2 && mid_wr) begin
                cfg_we = 1'b1; cfg_sel = 3'd6; cfg_wdata = {28'd0, mid_ctl};
            end
            @(negedge clk);
            cfg_we = 1'b0;
            if (gap && b < 5) begin
                rx_vld = 1'b0;
                check("R8 no early strobe", {63'd0, dec_vld}, 64'd0);
                @(negedge clk);
            end
        end
        rx_vld = 1'b0;
        check("R8 strobe after sixth byte", {63'd0, dec_vld}, 64'd1);
        acc = dec_accept;
        if (extra) begin
            for (int k = 0; k < 3; k++) begin
                rx_vld = 1'b1; rx_byte = 8'hFF;
                @(negedge clk);
                check("R8 extra bytes ignored", {63'd0, dec_vld}, 64'd0);
            end
            rx_vld = 1'b0;
        end else begin
            @(negedge clk);
            check("R8 strobe one cycle", {63'd0, dec_vld}, 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic        acc;
        logic [47:0] uc, mc, a;
        logic [47:0] kinds [6];
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        frm_start = 1'b0; frm_len = '0; rx_vld = 1'b0; rx_byte = '0;
        m_sta0 = '0; m_sta1 = '0; m_tbl = '0; m_ctl = '0;
        repeat (3) @(negedge clk);
        check("R10 strobe low in reset", {63'd0, dec_vld}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 strobe low after reset", {63'd0, dec_vld}, 64'd0);

        // R8: bytes before any frame start give no strobe
        for (int b = 0; b < 7; b++) begin
            rx_vld = 1'b1; rx_byte = 8'(b);
            @(negedge clk);
            check("R8 stray bytes", {63'd0, dec_vld}, 64'd0);
        end
        rx_vld = 1'b0;

        // R10: nothing programmed -> broadcast dropped
        frame(48'hFFFF_FFFF_FFFF, 64, 0, 0, 0, 4'd0, acc);
        check("R10 reset config drops", {63'd0, acc}, 64'd0);

        wr(3'd0, 32'h0302_0100); wr(3'd1, 32'hDEAD_0504);
        wr(3'd2, 32'hD4C3_B2A1); wr(3'd3, 32'h0000_F6E5);
        m_sta0 = 48'h0504_0302_0100;

        wr(3'd6, 32'h1);
        frame(48'h0504_0302_0100, 64, 0, 0, 0, 4'd0, acc);
        check("R1 station 0 hit", {63'd0, acc}, 64'd1);
        frame(48'hF6E5_D4C3_B2A1, 64, 0, 0, 0, 4'd0, acc);
        check("R6 station 1 disabled drop", {63'd0, acc}, 64'd0);
        wr(3'd6, 32'h2);
        frame(48'hF6E5_D4C3_B2A1, 64, 1, 0, 0, 4'd0, acc);
        check("R2 station 1 hit with gaps", {63'd0, acc}, 64'd1);
        frame(48'h0504_0302_0100, 64, 0, 0, 0, 4'd0, acc);
        check("R2 station 0 off", {63'd0, acc}, 64'd0);
        wr(3'd6, 32'h8);
        frame(48'hFFFF_FFFF_FFFF, 64, 0, 1, 0, 4'd0, acc);
        check("R3 broadcast on", {63'd0, acc}, 64'd1);
        wr(3'd6, 32'h0);
        frame(48'hFFFF_FFFF_FFFF, 64, 0, 0, 0, 4'd0, acc);
        check("R3 broadcast off", {63'd0, acc}, 64'd0);
        wr(3'd7, 32'hF);
        frame(48'hFFFF_FFFF_FFFF, 64, 0, 0, 0, 4'd0, acc);
        check("R6 select 7 ignored", {63'd0, acc}, 64'd0);

        wr(3'd6, 32'h1);
        frame(48'h0504_0302_0100, 11, 0, 0, 0, 4'd0, acc);
        check("R7 length 11 drop", {63'd0, acc}, 64'd0);
        frame(48'h0504_0302_0100, 12, 0, 0, 0, 4'd0, acc);
        check("R7 length 12 kept", {63'd0, acc}, 64'd1);

        // R9: control cleared mid-frame does not affect this frame, only the next
        frame(48'h0504_0302_0100, 64, 0, 0, 1, 4'd0, acc);
        check("R9 mid-frame write deferred", {63'd0, acc}, 64'd1);
        m_ctl = 4'd0;
        frame(48'h0504_0302_0100, 64, 0, 0, 0, 4'd0, acc);
        check("R9 write applies next frame", {63'd0, acc}, 64'd0);

        // R4: walk one table bit over every index
        for (int i = 0; i < 64; i++) begin
            wr(3'd4, 32'(64'h1 << i)); wr(3'd5, 32'((64'h1 << i) >> 32));
            a = 48'h3C5A_9E11_7701;
            a = a ^ (48'(fold(a) ^ 6'(i)) << 6);
            frame(a, 64, 0, 0, 0, 4'd0, acc);
            check($sformatf("R4 index %0d hit", i), {63'd0, acc}, 64'd1);
            frame(a ^ 48'h1000, 64, 0, 0, 0, 4'd0, acc);
            check($sformatf("R4 index %0d neighbour miss", i), {63'd0, acc}, 64'd0);
        end

        // R5: individual address with a table hit
        uc = 48'h1234_5678_9ABC;
        wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0);
        frame(uc, 64, 0, 0, 0, 4'd0, acc);
        check("R5 individual not hashed", {63'd0, acc}, 64'd0);
        wr(3'd6, 32'h4);
        frame(uc, 64, 0, 0, 0, 4'd0, acc);
        check("R5 individual hashed", {63'd0, acc}, 64'd1);

        // R6 sweep: every control word against several address kinds and lengths
        mc = 48'h0000_5E00_0101;
        wr(3'd4, 32'(((64'h1 << fold(uc)) | (64'h1 << fold(mc)))));
        wr(3'd5, 32'(((64'h1 << fold(uc)) | (64'h1 << fold(mc))) >> 32));
        kinds[0] = m_sta0; kinds[1] = m_sta1; kinds[2] = 48'hFFFF_FFFF_FFFF;
        kinds[3] = mc; kinds[4] = uc; kinds[5] = mc ^ 48'h40;
        for (int c = 0; c < 16; c++) begin
            wr(3'd6, 32'(c));
            for (int k = 0; k < 6; k++) begin
                for (int l = 0; l < 2; l++) begin
                    frame(kinds[k], (l == 0) ? 64 : 11, 0, 0, 0, 4'd0, acc);
                    check($sformatf("R6 ctl=%0d kind=%0d len=%0d", c, k, (l == 0) ? 64 : 11),
                          {63'd0, acc}, {63'd0, model(kinds[k], (l == 0) ? 64 : 11)});
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule